// File: doc/BRIEF.md
# Two-Port Handshake Mailbox

This block lets two processors, called side A and side B, pass 32-bit message words to each other. Each side has its own simple register port made of a select strobe, a write strobe, a byte address and a write data word. Read data comes back combinationally in the same cycle as a read strobe. The block holds four word registers. Word 0x000 is the message travelling from A to B. Word 0x004 is A's control view. Word 0x008 is the message travelling from B to A. Word 0x00C is B's control view. Side B reaches all four words, while side A reaches only the first three.

The handshake flags are four single flops, and each one appears in both control views. A set-bit written from the side that owns a flag raises it. A clear-bit written from the other side lowers it. A typical exchange from A to B runs as follows:
- A stores the message word and raises its send-request flag.
- B sees the flag as message-received and clears it.
- B reads the message and raises its receive-acknowledge flag.
- A sees that flag as sent-acknowledged and clears it.

The exchange from B to A runs the same way with the roles swapped. Each control view also holds two interrupt-enable bits. Each side has a registered interrupt output, driven by a two-state machine. The state `IRQ_QUIET` moves to `IRQ_ASSERTED` on the transition *raise*, which happens at any edge where an enabled cause is present. It moves back on the transition *drop*, which happens at any edge where no enabled cause remains.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all four words read as zero from every port that can reach them, and both interrupt outputs are low.
- R2: Words 0x000 and 0x008 are 32-bit read/write storage. Both ports can write them and both ports can read them, so a word written from one side reads back the same from either side.
- R3: A's control view (0x004) reads bit0 = A send-request, bit1 = A sent-ack, bit2 = A msg-received, bit3 = A recv-ack, bit4 = A receive-interrupt enable, bit5 = A sent-interrupt enable. B's view (0x00C) has the same layout for side B. All other bits read zero.
- R4: Writing 1 to bit0 at 0x004 raises the A-to-B request flag, which reads as bit0 at 0x004 and as bit2 at 0x00C. Writing 1 to bit2 at 0x00C lowers it.
- R5: Writing 1 to bit0 at 0x00C raises the B-to-A request flag, which reads as bit0 at 0x00C and as bit2 at 0x004. Writing 1 to bit2 at 0x004 lowers it.
- R6: Writing 1 to bit3 at 0x004 raises a flag that reads as bit3 at 0x004 and bit1 at 0x00C; writing 1 to bit1 at 0x00C lowers it. Writing 1 to bit3 at 0x00C raises a flag that reads as bit3 at 0x00C and bit1 at 0x004; writing 1 to bit1 at 0x004 lowers it.
- R7: A zero written to any flag bit leaves that flag unchanged. Bits 4 and 5 take the written value on every write to their control word.
- R8: When a flag is raised and lowered in the same cycle, it ends up raised.
- R9: An interrupt output is high in the cycle after its side has (msg-received AND bit4) OR (sent-ack AND bit5). It goes low in the cycle after that condition ends.
- R10: Writing 0x06 to both 0x004 and 0x00C clears all four handshake flags.
- R11: Port A accesses to 0x00C, and accesses from either port to any address with bits [1:0] nonzero or with any bit above bit 3 set, read zero and change nothing.
- R12: A port-B write to 0x004 has exactly the effect an A write of the same value would have. When both ports write the same word in one cycle, port A's data sets the enable bits and the message word, and the flag set/clear actions of both writes are combined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Port A access strobe |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A byte address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not reading |
| b_sel | input | 1 | Port B access strobe |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B byte address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not reading |
| a_irq | output | 1 | Side A interrupt |
| b_irq | output | 1 | Side B interrupt |

## Verification
A write takes effect at the edge that ends its cycle. A read strobe in the next cycle therefore returns the new value combinationally. An interrupt changes one edge after that, because the cause register sits between the flags and the pin. The bench drives each access just after a rising edge and samples every output at the falling edge. It compares both read buses and both interrupts against a behavioural model that is advanced at every rising edge. The directed interrupt checks look once at the falling edge right after the causing write has committed, when the old level is expected, and once a cycle later, when the new level is expected.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    typedef enum logic [1:0] {
        W_MSG_AB = 2'd0,
        W_CTRL_A = 2'd1,
        W_MSG_BA = 2'd2,
        W_CTRL_B = 2'd3
    } word_e;

    localparam int NUM_WORDS  = 4;
    localparam int CB_SEND    = 0;
    localparam int CB_SENT    = 1;
    localparam int CB_RECV    = 2;
    localparam int CB_ACK     = 3;
    localparam int CB_IE_RECV = 4;
    localparam int CB_IE_SENT = 5;
    localparam int CTRL_BITS  = 6;

    localparam int NUM_FLAGS  = 4;
    localparam int F_REQ_AB   = 0;
    localparam int F_REQ_BA   = 1;
    localparam int F_ACK_A2B  = 2;
    localparam int F_ACK_B2A  = 3;

    typedef enum logic {
        IRQ_QUIET    = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/ipc_reg_port.sv
module ipc_reg_port
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 32,
    parameter bit HAS_WORD3 = 1'b1
) (
    input  logic                            sel,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
    output logic [NUM_WORDS-1:0]            we,
    output logic [DATA_W-1:0]               rdata
);

    word_e idx;
    logic  mapped;

    always_comb begin
        idx    = word_e'(addr[3:2]);
        mapped = (addr[1:0] == 2'b00) && ((addr >> 4) == '0)
                 && (HAS_WORD3 || (idx != W_CTRL_B));
    end

    always_comb begin
        we = '0;
        if (sel && wr && mapped) begin
            we[idx] = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr && mapped) begin
            unique case (idx)
                W_MSG_AB: rdata = words[0];
                W_CTRL_A: rdata = words[1];
                W_MSG_BA: rdata = words[2];
                W_CTRL_B: rdata = HAS_WORD3 ? words[3] : '0;
            endcase
        end
    end

endmodule

// File: rtl/ipc_hs_flag.sv
module ipc_hs_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);

    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(q));

endmodule

// File: rtl/ipc_irq_fsm.sv
module ipc_irq_fsm
    import ipc_mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic recv_flag,
    input  logic sent_flag,
    input  logic ie_recv,
    input  logic ie_sent,
    output logic irq
);

    irq_state_e state, state_nx;
    logic       cause;

    always_comb begin
        cause    = (recv_flag && ie_recv) || (sent_flag && ie_sent);
        state_nx = state;
        unique case (state)
            IRQ_QUIET:    if (cause)  state_nx = IRQ_ASSERTED;
            IRQ_ASSERTED: if (!cause) state_nx = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= IRQ_QUIET;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        irq = (state == IRQ_ASSERTED);
    end

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((recv_flag && ie_recv) || (sent_flag && ie_sent)) |=> irq);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((recv_flag && ie_recv) || (sent_flag && ie_sent)) |=> !irq);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_sel,
    input  logic              a_wr,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              a_irq,
    output logic              b_irq
);

    localparam int PAD_W = DATA_W - CTRL_BITS;

    logic [NUM_WORDS-1:0]             a_we, b_we;
    logic [NUM_WORDS-1:0][DATA_W-1:0] reg_words;
    logic [NUM_FLAGS-1:0]             flag_set, flag_clr, flag_q;
    logic [1:0]                       ie_a, ie_b;
    logic [DATA_W-1:0]                msg_ab, msg_ba;
    logic [CTRL_BITS-1:0]             view_a, view_b;
    logic                             a_hits_actl, b_hits_actl, b_hits_bctl;

    // ---- register ports ----
    ipc_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_WORD3(1'b0)) u_port_a (
        .sel   (a_sel),
        .wr    (a_wr),
        .addr  (a_addr),
        .words (reg_words),
        .we    (a_we),
        .rdata (a_rdata)
    );

    ipc_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_WORD3(1'b1)) u_port_b (
        .sel   (b_sel),
        .wr    (b_wr),
        .addr  (b_addr),
        .words (reg_words),
        .we    (b_we),
        .rdata (b_rdata)
    );

    // ---- flag set / clear routing ----
    always_comb begin
        a_hits_actl = a_we[W_CTRL_A];
        b_hits_actl = b_we[W_CTRL_A];
        b_hits_bctl = b_we[W_CTRL_B];

        flag_set[F_REQ_AB]  = (a_hits_actl && a_wdata[CB_SEND]) || (b_hits_actl && b_wdata[CB_SEND]);
        flag_clr[F_REQ_AB]  = b_hits_bctl && b_wdata[CB_RECV];

        flag_set[F_REQ_BA]  = b_hits_bctl && b_wdata[CB_SEND];
        flag_clr[F_REQ_BA]  = (a_hits_actl && a_wdata[CB_RECV]) || (b_hits_actl && b_wdata[CB_RECV]);

        flag_set[F_ACK_A2B] = (a_hits_actl && a_wdata[CB_ACK]) || (b_hits_actl && b_wdata[CB_ACK]);
        flag_clr[F_ACK_A2B] = b_hits_bctl && b_wdata[CB_SENT];

        flag_set[F_ACK_B2A] = b_hits_bctl && b_wdata[CB_ACK];
        flag_clr[F_ACK_B2A] = (a_hits_actl && a_wdata[CB_SENT]) || (b_hits_actl && b_wdata[CB_SENT]);
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        ipc_hs_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[gi]),
            .clr   (flag_clr[gi]),
            .q     (flag_q[gi])
        );
    end

    // ---- enables and message words ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_a   <= '0;
            ie_b   <= '0;
            msg_ab <= '0;
            msg_ba <= '0;
        end else begin
            if (a_we[W_CTRL_A]) begin
                ie_a <= {a_wdata[CB_IE_SENT], a_wdata[CB_IE_RECV]};
            end else if (b_we[W_CTRL_A]) begin
                ie_a <= {b_wdata[CB_IE_SENT], b_wdata[CB_IE_RECV]};
            end
            if (b_we[W_CTRL_B]) begin
                ie_b <= {b_wdata[CB_IE_SENT], b_wdata[CB_IE_RECV]};
            end
            if (a_we[W_MSG_AB]) begin
                msg_ab <= a_wdata;
            end else if (b_we[W_MSG_AB]) begin
                msg_ab <= b_wdata;
            end
            if (a_we[W_MSG_BA]) begin
                msg_ba <= a_wdata;
            end else if (b_we[W_MSG_BA]) begin
                msg_ba <= b_wdata;
            end
        end
    end

    // ---- per-side control views ----
    always_comb begin
        view_a = {ie_a[1], ie_a[0], flag_q[F_ACK_A2B], flag_q[F_REQ_BA],
                  flag_q[F_ACK_B2A], flag_q[F_REQ_AB]};
        view_b = {ie_b[1], ie_b[0], flag_q[F_ACK_B2A], flag_q[F_REQ_AB],
                  flag_q[F_ACK_A2B], flag_q[F_REQ_BA]};
        reg_words[W_MSG_AB] = msg_ab;
        reg_words[W_CTRL_A] = {{PAD_W{1'b0}}, view_a};
        reg_words[W_MSG_BA] = msg_ba;
        reg_words[W_CTRL_B] = {{PAD_W{1'b0}}, view_b};
    end

    // ---- interrupts ----
    ipc_irq_fsm u_irq_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .recv_flag (flag_q[F_REQ_BA]),
        .sent_flag (flag_q[F_ACK_B2A]),
        .ie_recv   (ie_a[0]),
        .ie_sent   (ie_a[1]),
        .irq       (a_irq)
    );

    ipc_irq_fsm u_irq_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .recv_flag (flag_q[F_REQ_AB]),
        .sent_flag (flag_q[F_ACK_A2B]),
        .ie_recv   (ie_b[0]),
        .ie_sent   (ie_b[1]),
        .irq       (b_irq)
    );

    // R11
    a_cannot_touch_bctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sel && a_wr && (a_addr == ADDR_W'(12)) && !b_we[W_CTRL_B]) |=> $stable(ie_b));

    // R12
    a_wins_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we[W_CTRL_A] && b_we[W_CTRL_A]) |=>
            (ie_a == $past({a_wdata[CB_IE_SENT], a_wdata[CB_IE_RECV]})));

endmodule

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/100ps
module sim_ipc_mailbox;

    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_sel = 1'b0, a_wr = 1'b0, b_sel = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic          a_irq, b_irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    ipc_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .a_irq(a_irq), .b_irq(b_irq)
    );

    // ---------------- behavioural reference ----------------
    bit [31:0] m_msg0, m_msg2;
    bit        m_rq_ab, m_rq_ba, m_ak_a2b, m_ak_b2a;
    bit [1:0]  m_ie_a, m_ie_b;
    bit        m_irq_a, m_irq_b;

    function automatic int word_of(logic [AW-1:0] ad, bit is_a);
        if (ad[1:0] != 2'b00 || ad >= AW'(16)) return -1;
        if (is_a && ad[3:2] == 2'd3) return -1;
        return int'(ad[3:2]);
    endfunction

    function automatic logic [31:0] m_read(bit is_a, logic [AW-1:0] ad);
        int w;
        w = word_of(ad, is_a);
        case (w)
            0: return m_msg0;
            1: return {26'd0, m_ie_a, m_ak_a2b, m_rq_ba, m_ak_b2a, m_rq_ab};
            2: return m_msg2;
            3: return {26'd0, m_ie_b, m_ak_b2a, m_rq_ab, m_ak_a2b, m_rq_ba};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  wa, wb;
        bit  s0, c0, s1, c1, s2, c2, s3, c3;
        if (!rst_n) begin
            m_msg0 = 0; m_msg2 = 0;
            m_rq_ab = 0; m_rq_ba = 0; m_ak_a2b = 0; m_ak_b2a = 0;
            m_ie_a = 0; m_ie_b = 0; m_irq_a = 0; m_irq_b = 0;
        end else begin
            wa = (a_sel && a_wr) ? word_of(a_addr, 1'b1) : -1;
            wb = (b_sel && b_wr) ? word_of(b_addr, 1'b0) : -1;
            m_irq_a = (m_rq_ba && m_ie_a[0]) || (m_ak_b2a && m_ie_a[1]);
            m_irq_b = (m_rq_ab && m_ie_b[0]) || (m_ak_a2b && m_ie_b[1]);
            {s0, c0, s1, c1, s2, c2, s3, c3} = '0;
            if (wa == 1) begin
                s0 |= a_wdata[0]; c3 |= a_wdata[1]; c1 |= a_wdata[2]; s2 |= a_wdata[3];
            end
            if (wb == 1) begin
                s0 |= b_wdata[0]; c3 |= b_wdata[1]; c1 |= b_wdata[2]; s2 |= b_wdata[3];
            end
            if (wb == 3) begin
                s1 |= b_wdata[0]; c2 |= b_wdata[1]; c0 |= b_wdata[2]; s3 |= b_wdata[3];
            end
            if (s0) m_rq_ab = 1; else if (c0) m_rq_ab = 0;
            if (s1) m_rq_ba = 1; else if (c1) m_rq_ba = 0;
            if (s2) m_ak_a2b = 1; else if (c2) m_ak_a2b = 0;
            if (s3) m_ak_b2a = 1; else if (c3) m_ak_b2a = 0;
            if (wa == 1) m_ie_a = a_wdata[5:4]; else if (wb == 1) m_ie_a = b_wdata[5:4];
            if (wb == 3) m_ie_b = b_wdata[5:4];
            if (wa == 0) m_msg0 = a_wdata; else if (wb == 0) m_msg0 = b_wdata;
            if (wa == 2) m_msg2 = a_wdata; else if (wb == 2) m_msg2 = b_wdata;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tag_of(logic [AW-1:0] ad, bit is_a);
        case (word_of(ad, is_a))
            0, 2:    return "R2 message word";
            1, 3:    return "R3 control view";
            default: return "R11 unreachable address";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            chk({"A ", tag_of(a_addr, 1'b1)}, a_rdata, (a_sel && !a_wr) ? m_read(1'b1, a_addr) : 32'd0);
            chk({"B ", tag_of(b_addr, 1'b0)}, b_rdata, (b_sel && !b_wr) ? m_read(1'b0, b_addr) : 32'd0);
            chk("R9 a_irq vs model", {31'd0, a_irq}, {31'd0, m_irq_a});
            chk("R9 b_irq vs model", {31'd0, b_irq}, {31'd0, m_irq_b});
        end
    end

    // ---------------- bus tasks ----------------
    task automatic idle();
        @(posedge clk); #1;
        a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
    endtask

    task automatic a_put(logic [AW-1:0] ad, logic [31:0] d);
        @(posedge clk); #1;
        a_sel = 1; a_wr = 1; a_addr = ad; a_wdata = d; b_sel = 0; b_wr = 0;
    endtask

    task automatic b_put(logic [AW-1:0] ad, logic [31:0] d);
        @(posedge clk); #1;
        b_sel = 1; b_wr = 1; b_addr = ad; b_wdata = d; a_sel = 0; a_wr = 0;
    endtask

    task automatic both_put(logic [AW-1:0] aa, logic [31:0] ad, logic [AW-1:0] ba, logic [31:0] bd);
        @(posedge clk); #1;
        a_sel = 1; a_wr = 1; a_addr = aa; a_wdata = ad;
        b_sel = 1; b_wr = 1; b_addr = ba; b_wdata = bd;
    endtask

    task automatic a_get(logic [AW-1:0] ad, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        a_sel = 1; a_wr = 0; a_addr = ad; b_sel = 0; b_wr = 0;
        @(negedge clk);
        chk(tag, a_rdata, exp);
    endtask

    task automatic b_get(logic [AW-1:0] ad, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        b_sel = 1; b_wr = 0; b_addr = ad; a_sel = 0; a_wr = 0;
        @(negedge clk);
        chk(tag, b_rdata, exp);
    endtask

    task automatic irq_chk(bit ea, bit eb, string tag);
        @(negedge clk);
        chk({tag, " a_irq"}, {31'd0, a_irq}, {31'd0, ea});
        chk({tag, " b_irq"}, {31'd0, b_irq}, {31'd0, eb});
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        irq_chk(0, 0, "R1");
        a_get(6'h00, 0, "R1 msg AB"); a_get(6'h04, 0, "R1 ctrl A");
        a_get(6'h08, 0, "R1 msg BA"); b_get(6'h0C, 0, "R1 ctrl B");

        // R2 message storage
        a_put(6'h00, 32'hC0DE_1234); b_get(6'h00, 32'hC0DE_1234, "R2 B reads A msg");
        b_put(6'h08, 32'h5A5A_0F0F); a_get(6'h08, 32'h5A5A_0F0F, "R2 A reads B msg");
        a_get(6'h00, 32'hC0DE_1234, "R2 A readback");

        // R3 / R4 A-to-B request
        a_put(6'h04, 32'h01); a_get(6'h04, 32'h01, "R3 A view send");
        b_get(6'h0C, 32'h04, "R3 B view recv");
        b_put(6'h0C, 32'h04); a_get(6'h04, 0, "R4 cleared A view");
        b_get(6'h0C, 0, "R4 cleared B view");

        // R5 B-to-A request
        b_put(6'h0C, 32'h01); b_get(6'h0C, 32'h01, "R5 B send");
        a_get(6'h04, 32'h04, "R5 A recv");
        a_put(6'h04, 32'h04); b_get(6'h0C, 0, "R5 cleared B");
        a_get(6'h04, 0, "R5 cleared A");

        // R6 acknowledge pairs
        a_put(6'h04, 32'h08); a_get(6'h04, 32'h08, "R6 A ack");
        b_get(6'h0C, 32'h02, "R6 B sent");
        b_put(6'h0C, 32'h02); a_get(6'h04, 0, "R6 A ack cleared");
        b_put(6'h0C, 32'h08); b_get(6'h0C, 32'h08, "R6 B ack");
        a_get(6'h04, 32'h02, "R6 A sent");
        a_put(6'h04, 32'h02); b_get(6'h0C, 0, "R6 B ack cleared");

        // R7 zero writes and enables
        a_put(6'h04, 32'h01); a_put(6'h04, 32'h30);
        a_get(6'h04, 32'h31, "R7 enables with held flag");
        b_put(6'h0C, 32'h00); b_get(6'h0C, 32'h04, "R7 zero write from B");
        a_put(6'h04, 32'h00); a_get(6'h04, 32'h01, "R7 enables cleared");

        // R8 set beats clear
        b_put(6'h0C, 32'h04); b_get(6'h0C, 0, "R8 prep");
        both_put(6'h04, 32'h01, 6'h0C, 32'h04); b_get(6'h0C, 32'h04, "R8 request");
        both_put(6'h04, 32'h08, 6'h0C, 32'h02); b_get(6'h0C, 32'h06, "R8 ack");
        b_put(6'h0C, 32'h02); b_get(6'h0C, 32'h04, "R8 cleanup");

        // R9 interrupt timing, receive path on B
        b_put(6'h0C, 32'h10); idle();
        irq_chk(0, 0, "R9 b before");
        idle(); irq_chk(0, 1, "R9 b raised");
        b_put(6'h0C, 32'h14); idle();
        irq_chk(0, 1, "R9 b held one cycle");
        idle(); irq_chk(0, 0, "R9 b dropped");
        // R9 sent path on A
        a_put(6'h04, 32'h20); b_put(6'h0C, 32'h18); idle();
        irq_chk(0, 0, "R9 a before");
        idle(); irq_chk(1, 0, "R9 a raised");
        a_put(6'h04, 32'h22); idle();
        irq_chk(1, 0, "R9 a held one cycle");
        idle(); irq_chk(0, 0, "R9 a dropped");

        // R10 clear-all sequence, issued from port B to both words
        a_put(6'h04, 32'h29); b_put(6'h0C, 32'h19);
        a_get(6'h04, 32'h2F, "R10 A all set");
        b_get(6'h0C, 32'h1F, "R10 B all set");
        b_put(6'h04, 32'h06); b_put(6'h0C, 32'h06);
        a_get(6'h04, 0, "R10 A cleared"); b_get(6'h0C, 0, "R10 B cleared");
        idle(); idle(); irq_chk(0, 0, "R10 irqs");

        // R11 unreachable addresses
        a_put(6'h0C, 32'h3F); b_get(6'h0C, 0, "R11 A write to B ctrl");
        a_get(6'h0C, 0, "R11 A read of B ctrl");
        b_put(6'h10, 32'hFFFF_FFFF); a_get(6'h00, 32'hC0DE_1234, "R11 high address write");
        b_get(6'h10, 0, "R11 high address read");
        a_get(6'h02, 0, "R11 misaligned read");
        b_put(6'h09, 32'h0000_0001); a_get(6'h08, 32'h5A5A_0F0F, "R11 misaligned write");

        // R12 port B on A view, same-word collisions
        b_put(6'h04, 32'h01); a_get(6'h04, 32'h01, "R12 B sets A send");
        b_get(6'h0C, 32'h04, "R12 seen by B");
        both_put(6'h04, 32'h10, 6'h04, 32'h20); a_get(6'h04, 32'h11, "R12 A enable wins");
        both_put(6'h00, 32'h1111_2222, 6'h00, 32'h3333_4444);
        b_get(6'h00, 32'h1111_2222, "R12 A message wins");

        idle(); idle();
        finish_run();
    end

endmodule